// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit core and a data memory that is addressed by whole 32-bit words. It forms the effective address by adding a sign-extended 16-bit displacement to a base register value. For a load it picks the addressed byte or halfword out of the word read from memory and extends it to 32 bits, with sign or zero fill as the core requests. For a store it places the source data on every byte lane and drives a four-bit lane enable that selects the lanes to write.

One mode input selects the byte numbering inside a word. The lane selection for loads and the lane enables for stores both follow this mode. A halfword at an odd address, or a word at an address that is not a multiple of 4, raises an address-error flag and turns the access into a no-op. The unit is purely combinational, so each output follows its inputs within the same cycle.

Top module: `ls_lane_align`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `imm_offset` sign-extended to 32 bits, taken modulo 2^32.
- R2: Size code on `acc_size`: 00 is byte, 01 is halfword, 10 is word, and 11 behaves exactly like word.
- R3: Byte lane mapping. With `big_endian`=0, byte offset k = `eff_addr[1:0]` occupies bits [8k+7:8k]. With `big_endian`=1, offset k occupies bits [31-8k:24-8k]. Bit i of `byte_en` enables bits [8i+7:8i].
- R4: A byte load returns the selected byte in bits [7:0]. Bits [31:8] copy its bit 7 when `load_unsigned`=0 and are zero when `load_unsigned`=1.
- R5: A halfword load returns the halfword at offsets k and k+1 in bits [15:0]. The byte at offset k is the low byte in little-endian mode and the high byte in big-endian mode. Bits [31:16] are sign-filled when `load_unsigned`=0 and zero when `load_unsigned`=1.
- R6: An aligned word load returns `mem_rdata` unchanged in either byte order.
- R7: `addr_fault` is 1 for a halfword access with an odd address and for a word access whose address is not a multiple of 4; byte accesses never fault. When it is 1, `byte_en` is 0000 and `load_data` is zero.
- R8: `store_data` repeats the low byte of `store_src` in all four lanes for a byte access, repeats the low halfword in both halves for a halfword access, and equals `store_src` for a word access.
- R9: On an access without a fault, `byte_en` sets exactly the lanes that the addressed bytes occupy under R3: one lane for a byte, two for a halfword, all four for a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| big_endian | input | 1 | Byte order: 1 selects big-endian, 0 selects little-endian numbering |
| base_addr | input | 32 | Base register value |
| imm_offset | input | 16 | Signed displacement added to the base |
| acc_size | input | 2 | Access size code (00 byte, 01 half, 10/11 word) |
| load_unsigned | input | 1 | 1 zero-extends a byte or halfword load; 0 sign-extends it |
| mem_rdata | input | 32 | Word read from data memory |
| store_src | input | 32 | Source register value for a store |
| eff_addr | output | 32 | Effective byte address |
| load_data | output | 32 | Extended value for the destination register |
| store_data | output | 32 | Write data with the source replicated over the lanes |
| byte_en | output | 4 | Lane write enables |
| addr_fault | output | 1 | Misaligned access flag |

## Verification
The block has no parameters. The bench builds its single 32-bit configuration and sweeps the byte order as an input. That covers every byte offset under both numberings for each access size and both extension modes. The displacement sweep includes negative values, carries into the upper address bits and wrap past the top of the address space. Memory words with bit 7 or bit 15 of the selected field set show the difference between sign fill and zero fill.

// File: rtl/ls_lane_align.sv
module ls_lane_align (
  input  logic        big_endian,
  input  logic [31:0] base_addr,
  input  logic [15:0] imm_offset,
  input  logic [1:0]  acc_size,
  input  logic        load_unsigned,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] store_src,
  output logic [31:0] eff_addr,
  output logic [31:0] load_data,
  output logic [31:0] store_data,
  output logic [3:0]  byte_en,
  output logic        addr_fault
);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic [1:0]  ofs;
  logic [1:0]  lane;
  logic        half_hi;
  logic        is_b, is_h, is_w;
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  assign eff_addr = base_addr + {{16{imm_offset[15]}}, imm_offset};
  assign ofs      = eff_addr[1:0];

  assign is_b = (acc_size == SZ_BYTE);
  assign is_h = (acc_size == SZ_HALF);
  assign is_w = !is_b && !is_h;

  assign lane    = big_endian ? ~ofs : ofs;
  assign half_hi = big_endian ? ~ofs[1] : ofs[1];

  assign addr_fault = (is_h && ofs[0]) || (is_w && (ofs != 2'b00));

  assign byte_v = mem_rdata[{lane, 3'b000} +: 8];
  assign half_v = mem_rdata[{half_hi, 4'b0000} +: 16];

  always_comb begin
    if (addr_fault)
      load_data = '0;
    else if (is_b)
      load_data = {{24{byte_v[7] & ~load_unsigned}}, byte_v};
    else if (is_h)
      load_data = {{16{half_v[15] & ~load_unsigned}}, half_v};
    else
      load_data = mem_rdata;
  end

  always_comb begin
    if (addr_fault)
      byte_en = 4'b0000;
    else if (is_b)
      byte_en = 4'b0001 << lane;
    else if (is_h)
      byte_en = 4'b0011 << {half_hi, 1'b0};
    else
      byte_en = 4'b1111;
  end

  assign store_data = is_b ? {4{store_src[7:0]}} :
                      is_h ? {2{store_src[15:0]}} : store_src;

  always_comb begin
    p_fault_quiet_r7: assert (!addr_fault || (byte_en == 4'b0000 && load_data == 32'd0))
      else $error("fault without quiet outputs");
    p_byte_never_faults_r7: assert (!(acc_size == 2'b00) || !addr_fault)
      else $error("byte access faulted");
    p_lane_count_r9: assert (addr_fault ||
                             (acc_size == 2'b00 && $countones(byte_en) == 1) ||
                             (acc_size == 2'b01 && $countones(byte_en) == 2) ||
                             (acc_size[1] && byte_en == 4'b1111))
      else $error("lane enable count wrong");
    p_zero_fill_r4: assert (!(acc_size == 2'b00 && load_unsigned) || load_data[31:8] == 24'd0)
      else $error("unsigned byte load not zero filled");
    p_sign_fill_r5: assert (!(acc_size == 2'b01 && !load_unsigned) ||
                            load_data[31:16] == {16{load_data[15]}})
      else $error("signed half load not sign filled");
    p_byte_replica_r8: assert (!(acc_size == 2'b00) ||
                               (store_data[31:24] == store_data[7:0] &&
                                store_data[23:16] == store_data[7:0] &&
                                store_data[15:8]  == store_data[7:0]))
      else $error("byte store not replicated");
  end

endmodule

// File: tb/tb_ls_lane_align.sv
module tb_ls_lane_align;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        big_endian;
  logic [31:0] base_addr;
  logic [15:0] imm_offset;
  logic [1:0]  acc_size;
  logic        load_unsigned;
  logic [31:0] mem_rdata;
  logic [31:0] store_src;
  logic [31:0] eff_addr, load_data, store_data;
  logic [3:0]  byte_en;
  logic        addr_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ls_lane_align dut (
    .big_endian(big_endian), .base_addr(base_addr), .imm_offset(imm_offset),
    .acc_size(acc_size), .load_unsigned(load_unsigned), .mem_rdata(mem_rdata),
    .store_src(store_src), .eff_addr(eff_addr), .load_data(load_data),
    .store_data(store_data), .byte_en(byte_en), .addr_fault(addr_fault)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic be, input logic [31:0] w, input int k);
    return be ? w[31-8*k -: 8] : w[8*k +: 8];
  endfunction

  function automatic int lane_of(input logic be, input int k);
    return be ? 3 - k : k;
  endfunction

  task automatic drive(input logic be, input logic [31:0] addr, input logic [1:0] sz,
                       input logic uns, input logic [31:0] rd, input logic [31:0] src);
    @(negedge clk);
    big_endian = be; base_addr = addr; imm_offset = 16'h0000; acc_size = sz;
    load_unsigned = uns; mem_rdata = rd; store_src = src;
    #1;
  endtask

  task automatic t_idle;
    drive(1'b0, 32'h0, 2'b00, 1'b0, 32'h0, 32'h0);
    chk("R1", "idle addr", eff_addr, 32'h0);
    chk("R4", "idle load", load_data, 32'h0);
    chk("R9", "idle byte_en", {28'h0, byte_en}, 32'h1);
    chk("R7", "idle fault", {31'h0, addr_fault}, 32'h0);
  endtask

  task automatic t_addr_calc;
    logic [31:0] bases [4] = '{32'h0000_1000, 32'h0000_0004, 32'hFFFF_FFF0, 32'h1234_5678};
    logic [15:0] offs  [4] = '{16'h0010, 16'hFFF8, 16'h0020, 16'h8000};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      base_addr = bases[i]; imm_offset = offs[i]; acc_size = 2'b00;
      #1;
      chk("R1", "eff addr", eff_addr, bases[i] + {{16{offs[i][15]}}, offs[i]});
    end
  endtask

  task automatic t_byte_loads;
    logic [31:0] words [2] = '{32'h8A7F_C312, 32'h11F0_2299};
    for (int be = 0; be < 2; be++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++)
          for (int u = 0; u < 2; u++) begin
            logic [7:0] b;
            drive(be[0], 32'h100 + k, 2'b00, u[0], words[w], 32'h0);
            b = mbyte(be[0], words[w], k);
            chk("R4", "byte load", load_data, u ? {24'h0, b} : {{24{b[7]}}, b});
            chk("R3", "byte lane en", {28'h0, byte_en}, 32'h1 << lane_of(be[0], k));
          end
  endtask

  task automatic t_half_loads;
    logic [31:0] words [2] = '{32'h8001_7FFE, 32'h1234_F00D};
    for (int be = 0; be < 2; be++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k += 2)
          for (int u = 0; u < 2; u++) begin
            logic [15:0] h;
            logic [3:0]  en;
            drive(be[0], 32'h200 + k, 2'b01, u[0], words[w], 32'h0);
            h = be ? {mbyte(1'b1, words[w], k), mbyte(1'b1, words[w], k + 1)}
                   : {mbyte(1'b0, words[w], k + 1), mbyte(1'b0, words[w], k)};
            en = '0;
            en[lane_of(be[0], k)] = 1'b1;
            en[lane_of(be[0], k + 1)] = 1'b1;
            chk("R5", "half load", load_data, u ? {16'h0, h} : {{16{h[15]}}, h});
            chk("R9", "half byte_en", {28'h0, byte_en}, {28'h0, en});
          end
  endtask

  task automatic t_word_loads;
    for (int be = 0; be < 2; be++)
      for (int sz = 2; sz < 4; sz++) begin
        drive(be[0], 32'h300, sz[1:0], 1'b0, 32'hDEAD_BEEF, 32'h0);
        chk("R6", "word load", load_data, 32'hDEAD_BEEF);
        chk("R2", "word byte_en", {28'h0, byte_en}, 32'hF);
        chk("R7", "word no fault", {31'h0, addr_fault}, 32'h0);
      end
  endtask

  task automatic t_misalign;
    for (int be = 0; be < 2; be++) begin
      for (int k = 1; k < 4; k += 2) begin
        drive(be[0], 32'h400 + k, 2'b01, 1'b0, 32'hFFFF_FFFF, 32'h0);
        chk("R7", "odd half fault", {31'h0, addr_fault}, 32'h1);
        chk("R7", "odd half byte_en", {28'h0, byte_en}, 32'h0);
        chk("R7", "odd half load", load_data, 32'h0);
      end
      for (int k = 1; k < 4; k++)
        for (int sz = 2; sz < 4; sz++) begin
          drive(be[0], 32'h500 + k, sz[1:0], 1'b0, 32'hFFFF_FFFF, 32'h0);
          chk("R7", "word misalign fault", {31'h0, addr_fault}, 32'h1);
          chk("R7", "word misalign byte_en", {28'h0, byte_en}, 32'h0);
          chk("R2", "word misalign load", load_data, 32'h0);
        end
    end
    @(negedge clk);
    big_endian = 1'b0; base_addr = 32'h0000_0602; imm_offset = 16'hFFFF; acc_size = 2'b01;
    #1;
    chk("R7", "fault via displacement", {31'h0, addr_fault}, 32'h1);
  endtask

  task automatic t_stores;
    logic [31:0] src = 32'hA1B2_C3D4;
    drive(1'b0, 32'h700, 2'b00, 1'b0, 32'h0, src);
    chk("R8", "byte store data", store_data, 32'hD4D4_D4D4);
    drive(1'b1, 32'h701, 2'b00, 1'b0, 32'h0, src);
    chk("R8", "byte store data be", store_data, 32'hD4D4_D4D4);
    chk("R3", "byte store lane be", {28'h0, byte_en}, 32'h4);
    drive(1'b0, 32'h702, 2'b01, 1'b0, 32'h0, src);
    chk("R8", "half store data", store_data, 32'hC3D4_C3D4);
    chk("R9", "half store lanes le", {28'h0, byte_en}, 32'hC);
    drive(1'b1, 32'h700, 2'b01, 1'b0, 32'h0, src);
    chk("R9", "half store lanes be", {28'h0, byte_en}, 32'hC);
    drive(1'b1, 32'h704, 2'b10, 1'b0, 32'h0, src);
    chk("R8", "word store data", store_data, src);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_addr_calc();
    t_byte_loads();
    t_half_loads();
    t_word_loads();
    t_misalign();
    t_stores();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule